// File: doc/BRIEF.md
# Next Program Address Generator

This block sits beside the sequencer of a small byte-coded 8-bit controller. Each cycle it takes the address of the instruction now executing, how many bytes that instruction occupies, and a code that says how control is to move on. From these it works out the address of the next instruction. An instruction is one, two or three bytes long. The block handles four ways of moving on. It can step past the instruction. It can add a signed byte offset to that stepped address. It can replace the low 11 bits of the address with a field built from the opcode and one operand byte. It can load a full 16-bit target. An indexed jump is also supported, which adds the accumulator to the data pointer.

On the same cycle the block forms the code-memory address used for table lookups. That address is the zero-extended accumulator plus either the data pointer or the stepped address. For the two call forms, it captures the return address and then hands it out one byte at a time on a push port, low byte first and high byte second, so the stack logic can store it. Whether a conditional branch is taken is decided outside and arrives as a single flag. All address sums wrap modulo 2^16. Every result is registered and appears one clock after its inputs.

Top module: `npc_gen`

## Requirements
- R1: With `br_kind` = 0 (step), `npc_q` becomes `cur_pc + ins_len` one cycle after the inputs. Code 7 is unassigned and behaves the same way.
- R2: With `br_kind` = 1 (relative), `npc_q` becomes `cur_pc + ins_len + offset` when `take` is 1, and `cur_pc + ins_len` when `take` is 0. The offset is a sign-extended byte: `opnd2` when `ins_len` is 3, otherwise `opnd1`.
- R3: With `br_kind` = 2 (page jump) or 4 (page call), `npc_q` is built from three parts:
  - bits 15:11 are taken from `cur_pc + ins_len`;
  - bits 10:8 are taken from `opc[7:5]`;
  - bits 7:0 are taken from `opnd1`.
- R4: With `br_kind` = 3 (far jump) or 5 (far call), `npc_q` = {`opnd1`, `opnd2`}, where `opnd1` is the high byte.
- R5: With `br_kind` = 6 (indexed jump), `npc_q` = `dptr` + zero-extended `acc`.
- R6: Every cycle, `tbl_addr_q` becomes zero-extended `acc` plus `dptr` when `tbl_from_pc` is 0. When `tbl_from_pc` is 1, the second term is `cur_pc + ins_len` instead of `dptr`. The branch kind does not affect this address.
- R7: `take` has no effect on `npc_q` for any kind other than 1.
- R8: On a call (kind 4 or 5), `ret_lo_q` and `ret_hi_q` take the low and high bytes of `cur_pc + ins_len`. They hold their value on every non-call cycle.
- R9: After a call, `push_vld` is 1 for exactly two cycles. `push_byte` carries the return low byte one cycle after the call and the high byte two cycles after it. A call arriving during the sequence restarts it with the new address.
- R10: While `rst_n` is low, `npc_q`, `tbl_addr_q`, `ret_lo_q` and `ret_hi_q` are 0 and `push_vld` is 0.
- R11: All address sums wrap modulo 2^16. This applies both when stepping past 0xFFFF and when a negative offset goes below 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cur_pc | input | 16 | Address of the executing instruction |
| ins_len | input | 2 | Instruction length in bytes (1 to 3) |
| br_kind | input | 3 | How control moves on (codes in R1 to R5) |
| opc | input | 8 | Opcode byte |
| opnd1 | input | 8 | First operand byte |
| opnd2 | input | 8 | Second operand byte |
| acc | input | 8 | Accumulator |
| dptr | input | 16 | Data pointer |
| take | input | 1 | Branch condition result for relative branches |
| tbl_from_pc | input | 1 | Table base select: 0 data pointer, 1 stepped address |
| npc_q | output | 16 | Next program address |
| tbl_addr_q | output | 16 | Code-table read address |
| ret_lo_q | output | 8 | Low byte of the captured return address |
| ret_hi_q | output | 8 | High byte of the captured return address |
| push_vld | output | 1 | A return byte is offered on `push_byte` |
| push_byte | output | 8 | Return byte to push |

## Verification
`npc_q`, `tbl_addr_q` and the return bytes are all due one clock after the inputs that produce them. The bench therefore drives inputs on a falling edge and samples on the next falling edge, once the single rising edge between the two has passed. The push port is followed over three consecutive falling edges after a call: the low byte on the first, the high byte on the second, and idle on the third. For back-to-back calls, the bench checks that the second call overrides the high byte of the first. Release from reset passes through a two-stage synchroniser, so the bench waits several cycles after `rst_n` rises before it applies any vector.

// File: rtl/npc_pkg.sv
package npc_pkg;
  localparam int unsigned ADDR_W  = 16;
  localparam int unsigned BYTE_W  = 8;
  localparam int unsigned PAGE_W  = 11;
  localparam int unsigned LEN_W   = 2;

  typedef enum logic [2:0] {
    BK_STEP      = 3'd0,
    BK_REL       = 3'd1,
    BK_PAGE_JMP  = 3'd2,
    BK_FAR_JMP   = 3'd3,
    BK_PAGE_CALL = 3'd4,
    BK_FAR_CALL  = 3'd5,
    BK_IDX_JMP   = 3'd6,
    BK_SPARE     = 3'd7
  } brk_e;

  typedef enum logic [1:0] {
    PS_IDLE = 2'd0,
    PS_LO   = 2'd1,
    PS_HI   = 2'd2
  } push_st_e;
endpackage

// File: rtl/npc_target.sv
module npc_target
  import npc_pkg::*;
#(
  parameter int unsigned AW = ADDR_W,
  parameter int unsigned DW = BYTE_W,
  parameter int unsigned PW = PAGE_W,
  parameter int unsigned LW = LEN_W
) (
  input  brk_e            kind,
  input  logic            take,
  input  logic [LW-1:0]   len,
  input  logic [AW-1:0]   seq,
  input  logic [DW-1:0]   opc,
  input  logic [DW-1:0]   o1,
  input  logic [DW-1:0]   o2,
  input  logic [DW-1:0]   acc,
  input  logic [AW-1:0]   dptr,
  output logic [AW-1:0]   tgt,
  output logic            is_call
);
  localparam int unsigned OPF_W = PW - DW;
  localparam int unsigned EXT_W = AW - DW;
  localparam logic [LW-1:0] LEN_LONG = LW'(3);

  logic [DW-1:0] rel_byte;
  logic [AW-1:0] rel_ext;
  logic [AW-1:0] rel_tgt;
  logic [AW-1:0] page_tgt;
  logic [AW-1:0] far_tgt;
  logic [AW-1:0] idx_tgt;

  always_comb begin
    rel_byte = (len == LEN_LONG) ? o2 : o1;
    rel_ext  = {{EXT_W{rel_byte[DW-1]}}, rel_byte};
    rel_tgt  = seq + rel_ext;
    page_tgt = {seq[AW-1:PW], opc[DW-1 -: OPF_W], o1};
    far_tgt  = AW'({o1, o2});
    idx_tgt  = dptr + AW'(acc);
  end

  always_comb begin
    is_call = 1'b0;
    case (kind)
      BK_REL:       tgt = take ? rel_tgt : seq;
      BK_PAGE_JMP:  tgt = page_tgt;
      BK_PAGE_CALL: begin tgt = page_tgt; is_call = 1'b1; end
      BK_FAR_JMP:   tgt = far_tgt;
      BK_FAR_CALL:  begin tgt = far_tgt; is_call = 1'b1; end
      BK_IDX_JMP:   tgt = idx_tgt;
      default:      tgt = seq;
    endcase
  end
endmodule

// File: rtl/npc_table.sv
module npc_table
  import npc_pkg::*;
#(
  parameter int unsigned AW = ADDR_W,
  parameter int unsigned DW = BYTE_W
) (
  input  logic            from_pc,
  input  logic [DW-1:0]   acc,
  input  logic [AW-1:0]   dptr,
  input  logic [AW-1:0]   seq,
  output logic [AW-1:0]   addr
);
  logic [AW-1:0] base;

  always_comb begin
    base = from_pc ? seq : dptr;
    addr = base + AW'(acc);
  end
endmodule

// File: rtl/npc_push.sv
module npc_push
  import npc_pkg::*;
#(
  parameter int unsigned DW = BYTE_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic            call,
  input  logic [DW-1:0]   ret_lo,
  input  logic [DW-1:0]   ret_hi,
  output logic            vld,
  output logic [DW-1:0]   byte_o
);
  push_st_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    if (call) begin
      st_d = PS_LO;
    end else begin
      case (st_q)
        PS_LO:   st_d = PS_HI;
        PS_HI:   st_d = PS_IDLE;
        default: st_d = PS_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= PS_IDLE;
    end else if (en) begin
      st_q <= st_d;
    end
  end

  always_comb begin
    vld    = (st_q == PS_LO) || (st_q == PS_HI);
    byte_o = (st_q == PS_HI) ? ret_hi : ret_lo;
  end

  assert_hi_follows_lo_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == PS_HI) |-> ($past(st_q) == PS_LO));

  assert_no_third_byte_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == PS_HI) && !$past(call)) |=> !(st_q == PS_HI));
endmodule

// File: rtl/npc_gen.sv
module npc_gen
  import npc_pkg::*;
#(
  parameter int unsigned AW = ADDR_W,
  parameter int unsigned DW = BYTE_W,
  parameter int unsigned PW = PAGE_W,
  parameter int unsigned LW = LEN_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [AW-1:0]   cur_pc,
  input  logic [LW-1:0]   ins_len,
  input  logic [2:0]      br_kind,
  input  logic [DW-1:0]   opc,
  input  logic [DW-1:0]   opnd1,
  input  logic [DW-1:0]   opnd2,
  input  logic [DW-1:0]   acc,
  input  logic [AW-1:0]   dptr,
  input  logic            take,
  input  logic            tbl_from_pc,
  output logic [AW-1:0]   npc_q,
  output logic [AW-1:0]   tbl_addr_q,
  output logic [DW-1:0]   ret_lo_q,
  output logic [DW-1:0]   ret_hi_q,
  output logic            push_vld,
  output logic [DW-1:0]   push_byte
);
  brk_e          kind;
  logic [AW-1:0] seq_c;
  logic [AW-1:0] npc_c;
  logic [AW-1:0] tbl_c;
  logic          call_c;
  logic          rst_meta_q;
  logic          ld;

  // reset release synchroniser
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      ld         <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      ld         <= rst_meta_q;
    end
  end

  always_comb begin
    kind  = brk_e'(br_kind);
    seq_c = cur_pc + AW'(ins_len);
  end

  npc_target #(.AW(AW), .DW(DW), .PW(PW), .LW(LW)) u_tgt (
    .kind    (kind),
    .take    (take),
    .len     (ins_len),
    .seq     (seq_c),
    .opc     (opc),
    .o1      (opnd1),
    .o2      (opnd2),
    .acc     (acc),
    .dptr    (dptr),
    .tgt     (npc_c),
    .is_call (call_c)
  );

  npc_table #(.AW(AW), .DW(DW)) u_tbl (
    .from_pc (tbl_from_pc),
    .acc     (acc),
    .dptr    (dptr),
    .seq     (seq_c),
    .addr    (tbl_c)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      npc_q      <= '0;
      tbl_addr_q <= '0;
    end else if (ld) begin
      npc_q      <= npc_c;
      tbl_addr_q <= tbl_c;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ret_lo_q <= '0;
      ret_hi_q <= '0;
    end else if (ld && call_c) begin
      ret_lo_q <= seq_c[DW-1:0];
      ret_hi_q <= seq_c[AW-1:DW];
    end
  end

  npc_push #(.DW(DW)) u_push (
    .clk    (clk),
    .rst_n  (rst_n),
    .en     (ld),
    .call   (call_c),
    .ret_lo (ret_lo_q),
    .ret_hi (ret_hi_q),
    .vld    (push_vld),
    .byte_o (push_byte)
  );

  assert_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ld && (br_kind == 3'd0)) |-> (npc_q == $past(seq_c)));

  assert_page_keep_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ld && ((br_kind == 3'd2) || (br_kind == 3'd4))) |->
      ((npc_q[AW-1:PW] == $past(seq_c[AW-1:PW])) &&
       (npc_q[PW-1:DW] == $past(opc[DW-1 -: (PW-DW)]))));

  assert_ret_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ld && (br_kind != 3'd4) && (br_kind != 3'd5)) |->
      ($stable(ret_lo_q) && $stable(ret_hi_q)));

  assert_first_byte_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ld && call_c) |-> (push_vld && (push_byte == ret_lo_q)));

  assert_tbl_dptr_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ld && !tbl_from_pc) |-> (tbl_addr_q == $past(dptr + AW'(acc))));
endmodule

// File: tb/sim_npc_gen.sv
module sim_npc_gen;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 13;

  typedef struct packed {
    logic [15:0] pc;
    logic [1:0]  len;
    logic [2:0]  kind;
    logic [7:0]  opc;
    logic [7:0]  o1;
    logic [7:0]  o2;
    logic [7:0]  acc;
    logic [15:0] dptr;
    logic        take;
    logic        tsel;
    logic [15:0] e_npc;
    logic [15:0] e_tbl;
  } vec_t;

  // pc len kind opc o1 o2 acc dptr take tsel exp_npc exp_tbl
  localparam vec_t VECS [0:NVEC-1] = '{
    '{16'h1000, 2'd1, 3'd0, 8'h00, 8'h00, 8'h00, 8'h10, 16'h2000, 1'b0, 1'b0, 16'h1001, 16'h2010}, // R1 R6
    '{16'hFFFF, 2'd1, 3'd0, 8'h00, 8'h00, 8'h00, 8'h00, 16'h0000, 1'b0, 1'b1, 16'h0000, 16'h0000}, // R11 wrap
    '{16'h0200, 2'd2, 3'd1, 8'h80, 8'h05, 8'h00, 8'h03, 16'h0000, 1'b1, 1'b1, 16'h0207, 16'h0205}, // R2 fwd, R6 pc
    '{16'h0200, 2'd2, 3'd1, 8'h80, 8'hFE, 8'h00, 8'h00, 16'h1234, 1'b1, 1'b0, 16'h0200, 16'h1234}, // R2 back
    '{16'h0300, 2'd3, 3'd1, 8'hB4, 8'h40, 8'h10, 8'hFF, 16'hFFF0, 1'b0, 1'b0, 16'h0303, 16'h00EF}, // R2 not taken, R11
    '{16'h0300, 2'd3, 3'd1, 8'hB4, 8'h40, 8'h10, 8'h00, 16'h0000, 1'b1, 1'b0, 16'h0313, 16'h0000}, // R2 second operand
    '{16'h0000, 2'd2, 3'd1, 8'h80, 8'h80, 8'h00, 8'h00, 16'h0000, 1'b1, 1'b0, 16'hFF82, 16'h0000}, // R11 below zero
    '{16'h47FE, 2'd2, 3'd2, 8'hE1, 8'h34, 8'h00, 8'h00, 16'h0000, 1'b0, 1'b0, 16'h4F34, 16'h0000}, // R3 page cross
    '{16'h1000, 2'd3, 3'd3, 8'h02, 8'hAB, 8'hCD, 8'h02, 16'h0000, 1'b0, 1'b1, 16'hABCD, 16'h1005}, // R4 R6
    '{16'h0500, 2'd1, 3'd6, 8'h73, 8'h00, 8'h00, 8'h80, 16'hFFC0, 1'b0, 1'b0, 16'h0040, 16'h0040}, // R5 wrap
    '{16'h0100, 2'd3, 3'd0, 8'h00, 8'h10, 8'h20, 8'h00, 16'h0000, 1'b1, 1'b0, 16'h0103, 16'h0000}, // R7 step
    '{16'h47FE, 2'd2, 3'd2, 8'hE1, 8'h34, 8'h00, 8'h00, 16'h0000, 1'b1, 1'b0, 16'h4F34, 16'h0000}, // R7 page
    '{16'h0010, 2'd2, 3'd7, 8'h00, 8'h99, 8'h00, 8'h00, 16'h0000, 1'b1, 1'b0, 16'h0012, 16'h0000}  // R1 spare code
  };

  logic        clk;
  logic        rst_n;
  logic [15:0] cur_pc;
  logic [1:0]  ins_len;
  logic [2:0]  br_kind;
  logic [7:0]  opc, opnd1, opnd2, acc;
  logic [15:0] dptr;
  logic        take, tbl_from_pc;
  logic [15:0] npc_q, tbl_addr_q;
  logic [7:0]  ret_lo_q, ret_hi_q, push_byte;
  logic        push_vld;

  int n_chk;
  int n_bad;

  npc_gen u0 (
    .clk(clk), .rst_n(rst_n), .cur_pc(cur_pc), .ins_len(ins_len),
    .br_kind(br_kind), .opc(opc), .opnd1(opnd1), .opnd2(opnd2),
    .acc(acc), .dptr(dptr), .take(take), .tbl_from_pc(tbl_from_pc),
    .npc_q(npc_q), .tbl_addr_q(tbl_addr_q), .ret_lo_q(ret_lo_q),
    .ret_hi_q(ret_hi_q), .push_vld(push_vld), .push_byte(push_byte)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    cur_pc = v.pc; ins_len = v.len; br_kind = v.kind; opc = v.opc;
    opnd1 = v.o1; opnd2 = v.o2; acc = v.acc; dptr = v.dptr;
    take = v.take; tbl_from_pc = v.tsel;
  endtask

  task automatic idle_inputs();
    cur_pc = '0; ins_len = '0; br_kind = '0; opc = '0; opnd1 = '0;
    opnd2 = '0; acc = '0; dptr = '0; take = 1'b0; tbl_from_pc = 1'b0;
  endtask

  task automatic call_in(input logic [15:0] pc, input logic [2:0] kind,
                         input logic [7:0] op, input logic [7:0] b1, input logic [7:0] b2);
    idle_inputs();
    cur_pc = pc; br_kind = kind; opc = op; opnd1 = b1; opnd2 = b2;
    ins_len = (kind == 3'd5) ? 2'd3 : 2'd2;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired R10 actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    n_chk = 0; n_bad = 0;
    rst_n = 1'b0;
    idle_inputs();
    cur_pc = 16'h1234; ins_len = 2'd1;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10 npc", npc_q, 16'h0000);
    chk("R10 tbl", tbl_addr_q, 16'h0000);
    chk("R10 ret", {ret_hi_q, ret_lo_q}, 16'h0000);
    chk("R10 push_vld", {15'd0, push_vld}, 16'h0000);
    idle_inputs();
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    for (int i = 0; i < NVEC; i++) begin
      drive(VECS[i]);
      @(negedge clk);
      chk($sformatf("R1-vec%0d npc (R2 R3 R4 R5 R7 R11)", i), npc_q, VECS[i].e_npc);
      chk($sformatf("R6 vec%0d tbl", i), tbl_addr_q, VECS[i].e_tbl);
      chk($sformatf("R8 vec%0d ret hold", i), {ret_hi_q, ret_lo_q}, 16'h0000);
      chk($sformatf("R9 vec%0d no push", i), {15'd0, push_vld}, 16'h0000);
    end

    // R3 R8 R9 page call across a page edge
    call_in(16'h07FE, 3'd4, 8'h31, 8'h22, 8'h00);
    @(negedge clk);
    chk("R3 page call npc", npc_q, 16'h0922);
    chk("R8 ret after page call", {ret_hi_q, ret_lo_q}, 16'h0800);
    chk("R9 first push vld", {15'd0, push_vld}, 16'h0001);
    chk("R9 first push low byte", {8'd0, push_byte}, 16'h0000);
    idle_inputs();
    @(negedge clk);
    chk("R9 second push vld", {15'd0, push_vld}, 16'h0001);
    chk("R9 second push high byte", {8'd0, push_byte}, 16'h0008);
    @(negedge clk);
    chk("R9 push ends", {15'd0, push_vld}, 16'h0000);
    chk("R8 ret held", {ret_hi_q, ret_lo_q}, 16'h0800);

    // R4 R9 back-to-back far calls restart the sequence
    call_in(16'h8ABC, 3'd5, 8'h12, 8'h12, 8'h34);
    @(negedge clk);
    chk("R4 far call npc", npc_q, 16'h1234);
    chk("R8 far call ret", {ret_hi_q, ret_lo_q}, 16'h8ABF);
    chk("R9 far call low byte", {7'd0, push_vld, push_byte}, 16'h01BF);
    call_in(16'h1000, 3'd5, 8'h12, 8'h56, 8'h78);
    @(negedge clk);
    chk("R4 second call npc", npc_q, 16'h5678);
    chk("R9 restart low byte", {7'd0, push_vld, push_byte}, 16'h0103);
    idle_inputs();
    @(negedge clk);
    chk("R9 restart high byte", {7'd0, push_vld, push_byte}, 16'h0110);
    @(negedge clk);
    chk("R9 restart ends", {15'd0, push_vld}, 16'h0000);

    // R10 reset in mid-run clears outputs
    drive(VECS[0]);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R10 async npc clear", npc_q, 16'h0000);
    chk("R10 async ret clear", {ret_hi_q, ret_lo_q}, 16'h0000);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule